// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog peripheral on a simple register bus. Software programs a clock divider and starts an 8-bit up-counter. It must then reload the counter before the counter wraps. If the counter wraps while watchdog mode and the reset option are both on, the block drives a system reset output for a fixed number of clocks. Every wrap also raises an overflow flag, which software can read.

Each register is 16 bits wide. Every write carries a key byte in its upper half, and a write with the wrong key changes nothing, so a stray store cannot stop or reload the timer. The overflow flag is cleared in two steps. Software first reads the reset status register while the flag is set. Only then does writing the exact clear word take effect.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset every register reads 0. A write to byte address 0 with upper byte 0xA5 stores bit 6 (watchdog mode), bit 5 (count enable) and bits 2:0 (clock select). A read returns these at the same positions, with all other bits and the upper byte zero.
- R2: A write whose upper byte is not the key for its register leaves every register bit unchanged. The key is 0xA5 for address 0 and 0x5A for addresses 2 and 4; at address 4 the exact word 0xA500 is also accepted.
- R3: A write to byte address 2 with upper byte 0x5A loads the lower byte into the counter on the next edge. It overrides a tick that falls in the same cycle, and the counter reads back at address 2 in bits 7:0.
- R4: While enabled, the counter advances by one per divided period. Clock select 0..7 divides by 1, 64, 128, 256, 512, 1024, 4096 and 16384.
- R5: With the enable bit clear, the counter holds its value and the divider restarts from zero.
- R6: A tick at count 255 wraps the counter to 0 and sets the overflow flag, which reads as bit 7 at byte address 4.
- R7: A write to byte address 4 with upper byte 0x5A sets the reset-enable bit from bit 6; it reads back as bit 6 at address 4. Such a write never changes the flag.
- R8: Writing exactly 0xA500 to address 4 clears the flag only if a bus read of address 4 has seen the flag set since it was last set; otherwise the flag stays set.
- R9: A wrap in watchdog mode with reset enabled drives sysRstOut high for exactly 16 clocks, starting the cycle after the wrapping edge. A wrap in interval mode or with reset disabled leaves sysRstOut low.
- R10: Byte addresses other than 0, 2 and 4 read as 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 3 | Byte address of the access |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busRdEn | input | 1 | Read strobe; arms the flag clear when it reads address 4 |
| busWrData | input | 16 | Write data, key byte in bits 15:8 |
| busRdData | output | 16 | Combinational read data for busAddr |
| sysRstOut | output | 1 | Reset request pulse |

## Verification
The bench attacks the clear handshake. It writes the clear word before any read, then reads address 4 with the read strobe low. A design that clears without a read, or arms on a mere address match, loses the flag too early. Wrong-key writes go to every register and to an unmapped address; a design that checks only part of the key would change a field. The bench sets reset enable while in interval mode and expects no pulse. It also measures the pulse width at both the fastest and the slowest divider, which exposes an off-by-one in the pulse counter or a divider that uses the wrong ratio.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
  localparam int DATA_W = 16;
  localparam int CNT_W  = 8;
  localparam int SEL_W  = 3;
  localparam int PRE_W  = 14;

  typedef struct packed {
    logic             wdMode;
    logic             runEn;
    logic [SEL_W-1:0] clkSel;
    logic             rstEn;
  } cfg_t;

  typedef struct packed {
    logic             cntLoad;
    logic [CNT_W-1:0] loadVal;
    logic             flagClrReq;
    logic             flagRead;
  } strobe_t;

  function automatic logic [PRE_W:0] divOf(input logic [SEL_W-1:0] sel);
    logic [PRE_W:0] d;
    case (sel)
      3'd0:    d = 1;
      3'd1:    d = 1 << 6;
      3'd2:    d = 1 << 7;
      3'd3:    d = 1 << 8;
      3'd4:    d = 1 << 9;
      3'd5:    d = 1 << 10;
      3'd6:    d = 1 << 12;
      default: d = 1 << 14;
    endcase
    return d;
  endfunction
endpackage

// File: rtl/kwd_prescaler.sv
module kwd_prescaler
  import kwd_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             runEn,
  input  logic [SEL_W-1:0] clkSel,
  output logic             tick
);
  logic [PRE_W-1:0] preCnt;
  logic [PRE_W:0]   divLim;

  always_comb begin
    divLim = divOf(clkSel) - 1'b1;
    tick   = runEn && ({1'b0, preCnt} >= divLim);
  end

  always_ff @(posedge clk) begin
    if (!rstN)       preCnt <= '0;
    else if (!runEn) preCnt <= '0;
    else if (tick)   preCnt <= '0;
    else             preCnt <= preCnt + 1'b1;
  end

  AST_PRE_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    ($past(!runEn) && runEn && clkSel != '0) |-> !tick); // R5
endmodule

// File: rtl/kwd_ctrl.sv
module kwd_ctrl
  import kwd_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [DATA_W-1:0] busWrData,
  input  logic [CNT_W-1:0]  cntVal,
  input  logic              ovfFlag,
  output cfg_t              cfg,
  output strobe_t           stb,
  output logic [DATA_W-1:0] busRdData
);
  localparam logic [7:0]        KEY_CTRL  = 8'hA5;
  localparam logic [7:0]        KEY_CNT   = 8'h5A;
  localparam logic [7:0]        KEY_RST   = 8'h5A;
  localparam logic [DATA_W-1:0] CLR_WORD  = 16'hA500;
  localparam logic [ADDR_W-1:0] OFF_CTRL  = 0;
  localparam logic [ADDR_W-1:0] OFF_CNT   = 2;
  localparam logic [ADDR_W-1:0] OFF_RST   = 4;
  localparam int                BIT_MODE  = 6;
  localparam int                BIT_RUN   = 5;
  localparam int                BIT_RSTEN = 6;
  localparam int                BIT_FLAG  = 7;

  logic [7:0] keyByte;
  logic       hitCtrl, hitCnt, hitRst;
  logic       ctrlWrOk, rstWrOk;

  always_comb begin
    keyByte  = busWrData[DATA_W-1:8];
    hitCtrl  = busAddr == OFF_CTRL;
    hitCnt   = busAddr == OFF_CNT;
    hitRst   = busAddr == OFF_RST;
    ctrlWrOk = busWrEn && hitCtrl && keyByte == KEY_CTRL;
    rstWrOk  = busWrEn && hitRst && keyByte == KEY_RST;
    stb.cntLoad    = busWrEn && hitCnt && keyByte == KEY_CNT;
    stb.loadVal    = busWrData[CNT_W-1:0];
    stb.flagClrReq = busWrEn && hitRst && busWrData == CLR_WORD;
    stb.flagRead   = busRdEn && hitRst;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfg <= '0;
    end else begin
      if (ctrlWrOk) begin
        cfg.wdMode <= busWrData[BIT_MODE];
        cfg.runEn  <= busWrData[BIT_RUN];
        cfg.clkSel <= busWrData[SEL_W-1:0];
      end
      if (rstWrOk) cfg.rstEn <= busWrData[BIT_RSTEN];
    end
  end

  always_comb begin
    busRdData = '0;
    if (hitCtrl) begin
      busRdData[BIT_MODE]    = cfg.wdMode;
      busRdData[BIT_RUN]     = cfg.runEn;
      busRdData[SEL_W-1:0]   = cfg.clkSel;
    end else if (hitCnt) begin
      busRdData[CNT_W-1:0]   = cntVal;
    end else if (hitRst) begin
      busRdData[BIT_FLAG]    = ovfFlag;
      busRdData[BIT_RSTEN]   = cfg.rstEn;
    end
  end

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctrlWrOk, stb.cntLoad, rstWrOk, stb.flagClrReq})); // R2
  AST_BADKEY_CTRL: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && hitCtrl && keyByte != KEY_CTRL) |=>
      (cfg.wdMode == $past(cfg.wdMode) && cfg.runEn == $past(cfg.runEn)
       && cfg.clkSel == $past(cfg.clkSel))); // R2
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    busRdData[DATA_W-1:8] == 8'h00); // R1
  AST_RSTEN_TAKE: assert property (@(posedge clk) disable iff (!rstN)
    rstWrOk |=> cfg.rstEn == $past(busWrData[BIT_RSTEN])); // R7
endmodule

// File: rtl/kwd_datapath.sv
module kwd_datapath
  import kwd_pkg::*;
#(
  parameter int RST_CYCLES = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  cfg_t             cfg,
  input  strobe_t          stb,
  output logic [CNT_W-1:0] cntVal,
  output logic             ovfFlag,
  output logic             rstPulse
);
  localparam int PW = $clog2(RST_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  logic          tick;
  logic          wrapEv;
  logic          clrArmed;
  logic          clrNow;
  logic [PW-1:0] pulseCnt;

  kwd_prescaler u_pre (
    .clk    (clk),
    .rstN   (rstN),
    .runEn  (cfg.runEn),
    .clkSel (cfg.clkSel),
    .tick   (tick)
  );

  always_comb begin
    wrapEv = tick && !stb.cntLoad && cntVal == CNT_TOP;
    clrNow = stb.flagClrReq && clrArmed && ovfFlag;
  end

  always_ff @(posedge clk) begin
    if (!rstN)            cntVal <= '0;
    else if (stb.cntLoad) cntVal <= stb.loadVal;
    else if (tick)        cntVal <= cntVal + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ovfFlag  <= 1'b0;
      clrArmed <= 1'b0;
    end else if (wrapEv) begin
      ovfFlag  <= 1'b1;
      clrArmed <= 1'b0;
    end else if (clrNow) begin
      ovfFlag  <= 1'b0;
      clrArmed <= 1'b0;
    end else if (stb.flagRead && ovfFlag) begin
      clrArmed <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                                  pulseCnt <= '0;
    else if (wrapEv && cfg.wdMode && cfg.rstEn) pulseCnt <= PW'(RST_CYCLES);
    else if (pulseCnt != '0)                    pulseCnt <= pulseCnt - 1'b1;
  end

  assign rstPulse = pulseCnt != '0;

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !stb.cntLoad) |=> cntVal == CNT_W'($past(cntVal) + 1'b1)); // R4
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!cfg.runEn && !stb.cntLoad) |=> cntVal == $past(cntVal)); // R5
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rstN)
    stb.cntLoad |=> cntVal == $past(stb.loadVal)); // R3
  AST_FLAG_CLR_ARMED: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ovfFlag) |-> $past(clrArmed && stb.flagClrReq)); // R8
  AST_RST_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstPulse) |-> ovfFlag); // R9
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import kwd_pkg::*;
#(
  parameter int ADDR_W     = 3,
  parameter int RST_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [15:0]       busWrData,
  output logic [15:0]       busRdData,
  output logic              sysRstOut
);
  cfg_t             cfg;
  strobe_t          stb;
  logic [CNT_W-1:0] cntVal;
  logic             ovfFlag;

  kwd_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .busAddr   (busAddr),
    .busWrEn   (busWrEn),
    .busRdEn   (busRdEn),
    .busWrData (busWrData),
    .cntVal    (cntVal),
    .ovfFlag   (ovfFlag),
    .cfg       (cfg),
    .stb       (stb),
    .busRdData (busRdData)
  );

  kwd_datapath #(.RST_CYCLES(RST_CYCLES)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .cfg      (cfg),
    .stb      (stb),
    .cntVal   (cntVal),
    .ovfFlag  (ovfFlag),
    .rstPulse (sysRstOut)
  );
endmodule

// File: tb/keyed_watchdog_bench.sv
`timescale 1ns/1ps
module keyed_watchdog_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic        busRdEn = 1'b0;
  logic [15:0] busWrData = '0;
  logic [15:0] busRdData;
  logic        sysRstOut;

  int checks = 0;
  int errors = 0;
  int highCnt = 0;
  bit done = 1'b0;

  // behavioural reference state
  int mMode = 0, mRun = 0, mSel = 0, mRstEn = 0;
  int mCnt = 0, mPre = 0, mFlag = 0, mArmed = 0, mPulse = 0;

  always #10 clk = ~clk;

  keyed_watchdog u_keyed_watchdog (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busWrData(busWrData), .busRdData(busRdData),
    .sysRstOut(sysRstOut)
  );

  function automatic int divFor(int s);
    case (s)
      0: return 1;     1: return 64;    2: return 128;  3: return 256;
      4: return 512;   5: return 1024;  6: return 4096; default: return 16384;
    endcase
  endfunction

  function automatic int expRead(int a);
    case (a)
      0: return mMode * 64 + mRun * 32 + mSel;
      2: return mCnt;
      4: return mFlag * 128 + mRstEn * 64;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    int key, d, tk, wrap, load, clr;
    if (!rstN) begin
      mMode = 0; mRun = 0; mSel = 0; mRstEn = 0;
      mCnt = 0; mPre = 0; mFlag = 0; mArmed = 0; mPulse = 0;
    end else begin
      d = busWrData; key = d / 256;
      tk = (mRun != 0) && (mPre >= divFor(mSel) - 1);
      load = busWrEn && busAddr == 2 && key == 'h5A;
      wrap = tk && !load && mCnt == 255;
      clr = busWrEn && busAddr == 4 && d == 'hA500 && mArmed && mFlag;
      if (wrap && mMode && mRstEn) mPulse = 16;
      else if (mPulse > 0) mPulse = mPulse - 1;
      if (wrap) begin mFlag = 1; mArmed = 0; end
      else if (clr) begin mFlag = 0; mArmed = 0; end
      else if (busRdEn && busAddr == 4 && mFlag) mArmed = 1;
      if (!mRun || tk) mPre = 0; else mPre = mPre + 1;
      if (load) mCnt = d % 256;
      else if (tk) mCnt = (mCnt + 1) % 256;
      if (busWrEn && busAddr == 0 && key == 'hA5) begin
        mMode = (d >> 6) & 1; mRun = (d >> 5) & 1; mSel = d & 7;
      end
      if (busWrEn && busAddr == 4 && key == 'h5A) mRstEn = (d >> 6) & 1;
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rstN && !done) begin
      checks++;
      if (int'(busRdData) != expRead(int'(busAddr))) begin
        errors++;
        $display("FAIL %s model read addr %0d: got %h exp %h",
          busAddr == 0 ? "R1" : busAddr == 2 ? "R4" : busAddr == 4 ? "R6" : "R10",
          busAddr, busRdData, expRead(int'(busAddr)));
      end
      checks++;
      if (int'(sysRstOut) != int'(mPulse > 0)) begin
        errors++;
        $display("FAIL R9 model reset out: got %0d exp %0d", sysRstOut, mPulse > 0);
      end
      if (sysRstOut) highCnt++;
    end
  end

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk); #1;
    busAddr = 3'(a); busWrData = 16'(d); busWrEn = 1'b1;
    @(posedge clk); #1;
    busWrEn = 1'b0;
  endtask

  task automatic rd(input int a, input bit strobe, input string tag, input int exp);
    @(negedge clk); #1;
    busAddr = 3'(a); busRdEn = strobe;
    #4;
    chk(tag, int'(busRdData), exp);
    @(posedge clk); #1;
    busRdEn = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    idle(3);
    @(negedge clk); rstN = 1'b1;
    // R1 / R10 reset state
    rd(0, 1, "R1 reset ctrl", 0);
    rd(2, 1, "R1 reset cnt", 0);
    rd(4, 1, "R1 reset rst", 0);
    rd(6, 1, "R10 unmapped", 0);
    // R1 field storage and masking
    wr(0, 'hA5FF);
    rd(0, 1, "R1 ctrl fields", 'h0067);
    wr(0, 'hA500);
    rd(0, 1, "R1 ctrl stop", 0);
    // R2 wrong keys
    wr(0, 'h5A25); wr(2, 'hA511); wr(4, 'h1240); wr(4, 'hA540);
    rd(0, 1, "R2 ctrl unchanged", 0);
    rd(2, 1, "R2 cnt unchanged", 0);
    rd(4, 1, "R2 rst unchanged", 0);
    // R10 unmapped write
    wr(6, 'hA5FF); wr(7, 'h5A77);
    rd(0, 1, "R10 ctrl after unmapped", 0);
    rd(2, 1, "R10 cnt after unmapped", 0);
    // R3 load, R7 reset enable
    wr(2, 'h5A10);
    rd(2, 1, "R3 load", 'h10);
    wr(4, 'h5A40);
    rd(4, 1, "R7 reset enable", 'h40);
    // R4 divide by 64
    wr(2, 'h5A00);
    wr(0, 'hA521);
    idle(64 * 3 + 10);
    rd(2, 0, "R4 sel1 count", 3);
    // R5 hold
    wr(0, 'hA501);
    idle(2);
    rd(2, 0, "R5 hold a", mCnt);
    idle(500);
    rd(2, 0, "R5 hold b", 3);
    // R6 / R9 interval mode wrap, reset enabled
    wr(2, 'h5AFE);
    highCnt = 0;
    wr(0, 'hA520);
    idle(10);
    wr(0, 'hA500);
    chk("R9 no pulse in interval mode", highCnt, 0);
    rd(4, 0, "R6 flag set", 'hC0);
    // R8 clear without prior read
    wr(4, 'hA500);
    rd(4, 0, "R8 unarmed clear ignored", 'hC0);
    rd(4, 1, "R8 arming read", 'hC0);
    wr(4, 'h5A40);
    rd(4, 0, "R7 keyed write keeps flag", 'hC0);
    wr(4, 'hA500);
    rd(4, 0, "R8 armed clear", 'h40);
    // R9 watchdog wrap at fastest divider
    wr(2, 'h5AFF);
    highCnt = 0;
    wr(0, 'hA560);
    idle(40);
    wr(0, 'hA540);
    chk("R9 pulse width sel0", highCnt, 16);
    rd(4, 0, "R6 flag after wd wrap", 'hC0);
    // R9 with reset disabled
    wr(4, 'h5A00);
    wr(2, 'h5AFF);
    highCnt = 0;
    wr(0, 'hA560);
    idle(20);
    wr(0, 'hA540);
    chk("R9 no pulse when disabled", highCnt, 0);
    // R4 / R9 slowest divider
    wr(4, 'h5A40);
    wr(2, 'h5AFE);
    highCnt = 0;
    wr(0, 'hA567);
    idle(16384 * 2 - 100);
    chk("R4 sel7 not yet wrapped", highCnt, 0);
    idle(140);
    chk("R9 pulse width sel7", highCnt, 16);
    rd(2, 0, "R4 sel7 wrapped", 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired before R1..R10 sequence ended");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule